// File: doc/BRIEF.md
# Per-Port Programmable Input Debouncer

This block cleans up 32 digital input lines before the read and event logic sees them. The lines form four ports of eight. Each raw line first passes through a two-stage synchronizer. A port can then send its synchronized lines straight to the output (bypass), or through a stability filter. The filter changes an output line only after the synchronized input has held a new level, without a break, for a whole window.

Each port chooses one of four windows with its own 2-bit code. The windows are cycle counts of one fixed 8 MHz clock. With the default parameters they are 32, 512, 8000 and 64000 cycles, which is 4 µs, 64 µs, 1 ms and 8 ms. The enable byte and the duration byte come from registers outside this block. When a port's code changes, that port's stability counters start over. When a port first turns its filter on, its output is trusted only after three of its windows have passed.

Top module: `inport_debouncer`

## Requirements
- R1: For a bypassed port, an output line takes a new raw level two clock edges after the raw line changes. It still shows the old level after the first edge and the new level after the second.
- R2: Bit p of `flt_en` (p = 0..3) controls port p, which is lines 8p to 8p+7. A 1 filters the port and a 0 bypasses it.
- R3: Bits 7:4 of `flt_en` have no effect. A port whose own bit is 0 still shows bypass timing when those upper bits are all 1.
- R4: Bits [2p+1:2p] of `dur_code` select the window of port p. Code 00 selects WIN0, 01 selects WIN1, 10 selects WIN2 and 11 selects WIN3. The defaults are 32, 512, 8000 and 64000 cycles.
- R5: For a filtered port with window W, a raw line that changes before edge k and then holds is shown at the output after edge k+W+1. The output still shows the old level after edge k+W.
- R6: On a filtered port, a raw pulse that lasts fewer than W cycles never reaches the output. A pulse that lasts W cycles does reach the output, and the output returns to its old level once the raw line has been back at that level for the window.
- R7: If a port's code changes while that port is filtering, its counters restart at the first edge that sees the new code (edge c). An input that differs from the output is then shown after edge c+Wnew, where Wnew is the new window, whatever count had built up before.
- R8: While `rst_n` is low at a clock edge (synchronous, active low), every output line is 0 whatever the raw lines are.
- R9: A change on one port never changes the output of another port.
- R10: Turning on a port's filter while its inputs are steady does not change its output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock; 8 MHz for the default windows |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | NPORTS*PORT_W (32) | Raw input lines; port p is bits 8p+7:8p |
| flt_en | input | REG_W (8) | Per-port filter enable; bits above NPORTS unused |
| dur_code | input | REG_W (8) | Two-bit window code per port |
| dout | output | NPORTS*PORT_W (32) | Synchronized, optionally filtered lines |

## Verification
The bench uses short windows. For every port, every code and both enable settings, it checks the exact edge on which a step first shows at the output. A design that was off by one in the window compare, or that mapped a code or an enable bit to the wrong port, would move that edge or show bypass timing where filtering was expected. Pulses one cycle shorter than the window, equal to it and one cycle longer separate a filter that resets its count on a reversal from one that keeps counting up. A code change in the middle of a count catches a design that carries the old count into the new window: it would switch too early, or stall once the count had passed the new limit. Every check compares all 32 lines, so a leak from one port into another is caught.

// File: rtl/dbn_pkg.sv
// Package dbn_pkg
// Holds the code width and the helper functions for the counter size that the
// debouncer modules share. It assumes every window is at least one cycle long.
package dbn_pkg;

    localparam int CODE_W    = 2;
    localparam int NUM_CODES = 1 << CODE_W;

    // Largest of the four window lengths.
    function automatic int unsigned win_max(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Counter width that can hold the largest window minus one; never below 1.
    function automatic int cnt_width(input int unsigned longest);
        int w;
        w = $clog2(longest);
        if (w < 1) w = 1;
        return w;
    endfunction

endpackage

// File: rtl/din_sync.sv
// Module din_sync
// Two-flop synchronizer for a bus of independent raw lines. It assumes each line
// changes on its own, so a bus-wide skew of one cycle between lines is acceptable.
module din_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages per line, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

    // R1
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_q == $past(din, 2)));

endmodule

// File: rtl/bit_filter.sv
// Module bit_filter
// Stability filter for one synchronized line. Each cycle in which the input
// differs from the held level adds one to a counter. On the cycle the counter
// reaches lim_m1, the held level takes the input. A match, a restart or a bypass
// clears the counter. In bypass the held level follows the input, so a later
// enable starts from the current level. It assumes din is already synchronous.
module bit_filter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             restart,
    input  logic [CNT_W-1:0] lim_m1,
    input  logic             din,
    output logic             q
);

    logic [CNT_W-1:0] cnt;

    // Count mismatch cycles and take the new level when the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 1'b0;
        end else if (bypass) begin
            cnt <= '0;
            q   <= din;
        end else if (restart) begin
            cnt <= '0;
        end else if (din == q) begin
            cnt <= '0;
        end else if (cnt == lim_m1) begin
            cnt <= '0;
            q   <= din;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt <= lim_m1));

    // R7
    hold_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !bypass) |=> (q == $past(q)));

    // R6
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && din == q) |=> (q == $past(q)));

    // R10
    byp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (q == $past(din)));

endmodule

// File: rtl/port_filter.sv
// Module port_filter
// One port of PORT_W lines with a shared enable and a shared window code. It
// decodes the code into a window limit and registers the code it last saw, so a
// change restarts every counter of the port. It also picks, per port, between
// the filtered and the synchronized levels. It assumes the code is synchronous
// to clk.
module port_filter
    import dbn_pkg::*;
#(
    parameter int          PORT_W = 8,
    parameter int          CNT_W  = 16,
    parameter int unsigned WIN0   = 32,
    parameter int unsigned WIN1   = 512,
    parameter int unsigned WIN2   = 8000,
    parameter int unsigned WIN3   = 64000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout
);

    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(WIN0 - 1);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(WIN1 - 1);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(WIN2 - 1);
    localparam logic [CNT_W-1:0] LIM3 = CNT_W'(WIN3 - 1);

    logic [CODE_W-1:0] code_q;
    logic              restart;
    logic [CNT_W-1:0]  lim_m1;
    logic [PORT_W-1:0] held;

    // Remember the code in force, so a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code;
    end

    assign restart = (code != code_q);

    // Turn the window code into the last count of the window.
    always_comb begin
        case (code)
            2'b00:   lim_m1 = LIM0;
            2'b01:   lim_m1 = LIM1;
            2'b10:   lim_m1 = LIM2;
            default: lim_m1 = LIM3;
        endcase
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        bit_filter #(.CNT_W(CNT_W)) u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .bypass  (!enable),
            .restart (restart),
            .lim_m1  (lim_m1),
            .din     (din[i]),
            .q       (held[i])
        );
    end

    // Pick the filtered level, or the synchronized level in bypass.
    always_comb begin
        dout = enable ? held : din;
    end

    // R7
    code_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (code_q == $past(code)));

endmodule

// File: rtl/inport_debouncer.sv
// Module inport_debouncer
// Top of the input debouncer. It synchronizes all raw lines and then runs NPORTS
// port filters, one for each group of PORT_W lines. Each filter takes its own
// enable bit and its own window code from the register inputs. It assumes both
// register inputs are synchronous to clk; enable bits at and above NPORTS, and
// code fields above port NPORTS-1, are ignored.
module inport_debouncer
    import dbn_pkg::*;
#(
    parameter int          NPORTS = 4,
    parameter int          PORT_W = 8,
    parameter int          REG_W  = 8,
    parameter int unsigned WIN0   = 32,
    parameter int unsigned WIN1   = 512,
    parameter int unsigned WIN2   = 8000,
    parameter int unsigned WIN3   = 64000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS*PORT_W-1:0] raw_in,
    input  logic [REG_W-1:0]         flt_en,
    input  logic [REG_W-1:0]         dur_code,
    output logic [NPORTS*PORT_W-1:0] dout
);

    localparam int NBITS = NPORTS * PORT_W;
    localparam int CNT_W = cnt_width(win_max(WIN0, WIN1, WIN2, WIN3));

    logic [NBITS-1:0] sync_bus;

    din_sync #(.W(NBITS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_bus)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        port_filter #(
            .PORT_W (PORT_W),
            .CNT_W  (CNT_W),
            .WIN0   (WIN0),
            .WIN1   (WIN1),
            .WIN2   (WIN2),
            .WIN3   (WIN3)
        ) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (flt_en[p]),
            .code   (dur_code[p*CODE_W +: CODE_W]),
            .din    (sync_bus[p*PORT_W +: PORT_W]),
            .dout   (dout[p*PORT_W +: PORT_W])
        );
    end

    if (REG_W > NPORTS) begin : g_spare_en
        logic unused_en;
        assign unused_en = ^flt_en[REG_W-1:NPORTS];
    end

    if (REG_W > NPORTS * CODE_W) begin : g_spare_code
        logic unused_code;
        assign unused_code = ^dur_code[REG_W-1:NPORTS*CODE_W];
    end

    // R9
    port_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(raw_in) && $stable(flt_en) && $stable(dur_code) &&
         $past(rst_n) && $past($stable(raw_in)) && $past(rst_n, 2) &&
         (dout == sync_bus)) |=> $stable(dout));

endmodule

// File: tb/inport_debouncer_bench.sv
module inport_debouncer_bench;

    localparam int W0 = 4, W1 = 7, W2 = 11, W3 = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_in = '0;
    logic [7:0]  flt_en = '0;
    logic [7:0]  dur_code = '0;
    logic [31:0] dout;
    logic [31:0] expv = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    inport_debouncer #(
        .NPORTS(4), .PORT_W(8), .REG_W(8),
        .WIN0(W0), .WIN1(W1), .WIN2(W2), .WIN3(W3)
    ) u_inport_debouncer (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
        .flt_en(flt_en), .dur_code(dur_code), .dout(dout)
    );

    function automatic int win_of(input int code);
        case (code)
            0: return W0;
            1: return W1;
            2: return W2;
            default: return W3;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
        checks++;
        if (act !== want) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, want);
        end
    endtask

    task automatic set_port(input int p, input bit filt, input int code);
        @(negedge clk);
        flt_en[p] = filt;
        dur_code[2*p +: 2] = 2'(code);
        repeat (20) @(negedge clk);
    endtask

    // R1 R2 R4 R5 R9 R10: step a whole port and find the first edge that shows it
    task automatic step_test(input int p, input bit filt, input int code);
        int w;
        set_port(p, filt, code);
        chk(filt ? "R10 enable keeps level" : "R2 bypass steady", dout, expv);
        raw_in[p*8 +: 8] = ~raw_in[p*8 +: 8];
        if (filt) begin
            w = win_of(code);
            repeat (w + 1) @(posedge clk);
            @(negedge clk);
            chk("R5 old level at edge k+W", dout, expv);
            @(posedge clk);
            @(negedge clk);
            expv[p*8 +: 8] = raw_in[p*8 +: 8];
            chk("R4 R5 new level at edge k+W+1", dout, expv);
        end else begin
            @(posedge clk);
            @(negedge clk);
            chk("R1 old level after first edge", dout, expv);
            @(posedge clk);
            @(negedge clk);
            expv[p*8 +: 8] = raw_in[p*8 +: 8];
            chk("R1 R2 new level after second edge", dout, expv);
        end
    endtask

    // R6 R9: pulse of len cycles on a filtered port
    task automatic glitch_test(input int p, input int code, input int len);
        int w;
        bit seen;
        set_port(p, 1'b1, code);
        w = win_of(code);
        seen = 1'b0;
        raw_in[p*8 +: 8] = ~raw_in[p*8 +: 8];
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (dout !== expv) seen = 1'b1;
        end
        raw_in[p*8 +: 8] = ~raw_in[p*8 +: 8];
        for (int i = 0; i < w + 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (dout !== expv) seen = 1'b1;
        end
        chk("R6 pulse visibility", 32'(seen), 32'(len >= w));
        chk("R6 R9 settled after pulse", dout, expv);
    endtask

    // R7: change the code part way through a count
    task automatic codechg_test(input int p, input int c_from, input int c_to);
        int w;
        set_port(p, 1'b1, c_from);
        raw_in[p*8 +: 8] = ~raw_in[p*8 +: 8];
        repeat (3) @(posedge clk);
        @(negedge clk);
        dur_code[2*p +: 2] = 2'(c_to);
        w = win_of(c_to);
        repeat (w) @(posedge clk);
        @(negedge clk);
        chk("R7 old level at edge c+Wnew-1", dout, expv);
        @(posedge clk);
        @(negedge clk);
        expv[p*8 +: 8] = raw_in[p*8 +: 8];
        chk("R7 new level at edge c+Wnew", dout, expv);
    endtask

    initial begin
        raw_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        chk("R8 outputs zero in reset", dout, 32'h0);
        raw_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 outputs zero after reset", dout, 32'h0);

        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 4; c++)
                for (int f = 0; f < 2; f++)
                    step_test(p, f[0], c);

        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 4; c++) begin
                glitch_test(p, c, 1);
                glitch_test(p, c, win_of(c) - 1);
                glitch_test(p, c, win_of(c));
                glitch_test(p, c, win_of(c) + 1);
            end

        codechg_test(0, 3, 0);
        codechg_test(3, 0, 2);

        // R3: upper enable bits set, port 2 still bypassed
        @(negedge clk);
        flt_en = 8'hF0;
        repeat (20) @(negedge clk);
        raw_in[23:16] = ~raw_in[23:16];
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        expv[23:16] = raw_in[23:16];
        chk("R3 upper enable bits ignored", dout, expv);

        // R8: reset in the middle of a run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 mid-run reset clears outputs", dout, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule